// File: doc/BRIEF.md
# Instruction Field Decoder

This block takes a 32-bit instruction word with a valid strobe and splits it into an operation code, three register indices and a sign-extended immediate. It also sorts the word into one of four operand formats and flags codes that no operation uses. The decode logic is combinational, and one register stage sits behind it. That stage loads only when the strobe is high, so an execution stage downstream reads stable fields for as long as it needs them.

The format comes from where the operation code falls against three ordered boundaries:

| Codes | Format | Operands used |
|-------|--------|---------------|
| 0 to 10 | three-register arithmetic/logic | a, b, c |
| 11 to 24 | move, load/store, compare and branch | a, b and the 16-bit immediate |
| 25 and 26 | register jump | a only |
| 27 and above | operand-free | none |

Each format forces the operand outputs it does not use to zero. Any code above 27 has no operation and raises the illegal flag. The boundaries are parameters, so the same logic serves a different opcode map.

Top module: `insn_field_decoder`

## Requirements
- R1: While `rst` is high, and on the first edge after it, every output is zero (`o_valid`, `o_class`, `o_opcode`, `o_ra`, `o_rb`, `o_rc`, `o_imm`, `o_illegal`).
- R2: `o_valid` equals the `i_valid` sampled on the previous rising edge.
- R3: When `i_valid` is low on an edge, all field outputs keep their previous values.
- R4: One edge after a valid word, `o_opcode` equals instruction bits 31..26.
- R5: Codes 0 to 10 give `o_class` = 0. `o_ra`, `o_rb` and `o_rc` are taken from bits 25..21, 20..16 and 15..11, and `o_imm` is zero.
- R6: Codes 11 to 24 give `o_class` = 1. `o_ra` and `o_rb` are taken from bits 25..21 and 20..16, `o_rc` is zero, and `o_imm` is bits 15..0 sign-extended.
- R7: In class 1, an immediate of 0x8000 or above yields 0xFFFF in `o_imm[31:16]`, and one below 0x8000 yields zero there.
- R8: Codes 25 and 26 give `o_class` = 2. `o_ra` is taken from bits 25..21, and `o_rb`, `o_rc` and `o_imm` are zero.
- R9: Codes 27 and above give `o_class` = 3, and `o_ra`, `o_rb`, `o_rc` and `o_imm` are all zero.
- R10: `o_illegal` is 1 exactly for codes above 27 and 0 for codes 0 to 27.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| i_valid | input | 1 | Instruction word strobe |
| i_instr | input | 32 | Instruction word |
| o_valid | output | 1 | Registered strobe |
| o_class | output | 2 | Format: 0 ALU, 1 immediate, 2 jump, 3 operand-free |
| o_opcode | output | 6 | Operation code |
| o_ra | output | 5 | Register index a |
| o_rb | output | 5 | Register index b |
| o_rc | output | 5 | Register index c |
| o_imm | output | 32 | Sign-extended immediate |
| o_illegal | output | 1 | Unassigned operation code |

## Verification
The bench builds the decoder with its default parameters: 32-bit words, a 6-bit code, 5-bit register fields, a 16-bit immediate and boundaries at 11, 25 and 27. With a 6-bit code, all 64 codes can be swept, so every class edge (10/11, 24/25, 26/27 and 27/28) is hit along with every illegal code. Immediates on both sides of 0x8000 and idle gaps between words exercise sign extension and the hold behaviour.

// File: rtl/idec_pkg.sv
package idec_pkg;
  // Format classes of an instruction word.
  typedef enum logic [1:0] {
    CLS_ALU  = 2'd0,
    CLS_IMM  = 2'd1,
    CLS_JMP  = 2'd2,
    CLS_MISC = 2'd3
  } idec_class_e;

  // Default geometry of the instruction word.
  localparam int unsigned XLEN_D  = 32;
  localparam int unsigned OPC_W_D = 6;
  localparam int unsigned REG_W_D = 5;
  localparam int unsigned IMM_W_D = 16;

  // Default ordered class boundaries.
  localparam int unsigned MOV_BASE_D = 11;
  localparam int unsigned JMP_BASE_D = 25;
  localparam int unsigned SYS_BASE_D = 27;
  localparam int unsigned LAST_OPC_D = 27;
endpackage

// File: rtl/idec_fields.sv
module idec_fields #(
  parameter int unsigned XLEN  = idec_pkg::XLEN_D,
  parameter int unsigned OPC_W = idec_pkg::OPC_W_D,
  parameter int unsigned REG_W = idec_pkg::REG_W_D,
  parameter int unsigned IMM_W = idec_pkg::IMM_W_D
) (
  input  logic [XLEN-1:0]  i_word,
  output logic [OPC_W-1:0] o_opc,
  output logic [REG_W-1:0] o_fa,
  output logic [REG_W-1:0] o_fb,
  output logic [REG_W-1:0] o_fc,
  output logic [XLEN-1:0]  o_sext
);
  // Field positions, packed downward from the top of the word.
  localparam int unsigned OPC_LSB = XLEN - OPC_W;
  localparam int unsigned RA_LSB  = OPC_LSB - REG_W;
  localparam int unsigned RB_LSB  = RA_LSB - REG_W;
  localparam int unsigned RC_LSB  = RB_LSB - REG_W;
  localparam int unsigned EXT_W   = XLEN - IMM_W;

  logic [IMM_W-1:0] raw_imm;

  always_comb begin
    o_opc   = i_word[OPC_LSB +: OPC_W];
    o_fa    = i_word[RA_LSB  +: REG_W];
    o_fb    = i_word[RB_LSB  +: REG_W];
    o_fc    = i_word[RC_LSB  +: REG_W];
    raw_imm = i_word[IMM_W-1:0];
    o_sext  = {{EXT_W{raw_imm[IMM_W-1]}}, raw_imm};
  end
endmodule

// File: rtl/idec_classify.sv
module idec_classify
  import idec_pkg::*;
#(
  parameter int unsigned OPC_W    = OPC_W_D,
  parameter int unsigned MOV_BASE = MOV_BASE_D,
  parameter int unsigned JMP_BASE = JMP_BASE_D,
  parameter int unsigned SYS_BASE = SYS_BASE_D,
  parameter int unsigned LAST_OPC = LAST_OPC_D
) (
  input  logic [OPC_W-1:0] i_opc,
  output idec_class_e      o_cls,
  output logic             o_bad
);
  localparam logic [OPC_W-1:0] MOV_C  = OPC_W'(MOV_BASE);
  localparam logic [OPC_W-1:0] JMP_C  = OPC_W'(JMP_BASE);
  localparam logic [OPC_W-1:0] SYS_C  = OPC_W'(SYS_BASE);
  localparam logic [OPC_W-1:0] LAST_C = OPC_W'(LAST_OPC);

  always_comb begin
    if (i_opc < MOV_C)      o_cls = CLS_ALU;
    else if (i_opc < JMP_C) o_cls = CLS_IMM;
    else if (i_opc < SYS_C) o_cls = CLS_JMP;
    else                    o_cls = CLS_MISC;
    o_bad = (i_opc > LAST_C);
  end
endmodule

// File: rtl/idec_operand_mask.sv
module idec_operand_mask
  import idec_pkg::*;
#(
  parameter int unsigned XLEN  = XLEN_D,
  parameter int unsigned REG_W = REG_W_D
) (
  input  idec_class_e      i_cls,
  input  logic [REG_W-1:0] i_fa,
  input  logic [REG_W-1:0] i_fb,
  input  logic [REG_W-1:0] i_fc,
  input  logic [XLEN-1:0]  i_sext,
  output logic [REG_W-1:0] o_ra,
  output logic [REG_W-1:0] o_rb,
  output logic [REG_W-1:0] o_rc,
  output logic [XLEN-1:0]  o_imm
);
  // Zero every operand that the format does not use.
  always_comb begin
    o_ra  = '0;
    o_rb  = '0;
    o_rc  = '0;
    o_imm = '0;
    unique case (i_cls)
      CLS_ALU: begin
        o_ra = i_fa;
        o_rb = i_fb;
        o_rc = i_fc;
      end
      CLS_IMM: begin
        o_ra  = i_fa;
        o_rb  = i_fb;
        o_imm = i_sext;
      end
      CLS_JMP:  o_ra = i_fa;
      default: ;
    endcase
  end
endmodule

// File: rtl/insn_field_decoder.sv
module insn_field_decoder
  import idec_pkg::*;
#(
  parameter int unsigned XLEN     = XLEN_D,
  parameter int unsigned OPC_W    = OPC_W_D,
  parameter int unsigned REG_W    = REG_W_D,
  parameter int unsigned IMM_W    = IMM_W_D,
  parameter int unsigned MOV_BASE = MOV_BASE_D,
  parameter int unsigned JMP_BASE = JMP_BASE_D,
  parameter int unsigned SYS_BASE = SYS_BASE_D,
  parameter int unsigned LAST_OPC = LAST_OPC_D
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             i_valid,
  input  logic [XLEN-1:0]  i_instr,
  output logic             o_valid,
  output logic [1:0]       o_class,
  output logic [OPC_W-1:0] o_opcode,
  output logic [REG_W-1:0] o_ra,
  output logic [REG_W-1:0] o_rb,
  output logic [REG_W-1:0] o_rc,
  output logic [XLEN-1:0]  o_imm,
  output logic             o_illegal
);
  localparam int unsigned EXT_W = XLEN - IMM_W;

  // Combinational decode results.
  logic [OPC_W-1:0] dec_opc;
  logic [REG_W-1:0] fld_a, fld_b, fld_c;
  logic [XLEN-1:0]  fld_sext;
  idec_class_e      dec_cls;
  logic             dec_bad;
  logic [REG_W-1:0] msk_a, msk_b, msk_c;
  logic [XLEN-1:0]  msk_imm;

  idec_fields #(
    .XLEN(XLEN), .OPC_W(OPC_W), .REG_W(REG_W), .IMM_W(IMM_W)
  ) u_fields (
    .i_word (i_instr),
    .o_opc  (dec_opc),
    .o_fa   (fld_a),
    .o_fb   (fld_b),
    .o_fc   (fld_c),
    .o_sext (fld_sext)
  );

  idec_classify #(
    .OPC_W(OPC_W), .MOV_BASE(MOV_BASE), .JMP_BASE(JMP_BASE),
    .SYS_BASE(SYS_BASE), .LAST_OPC(LAST_OPC)
  ) u_classify (
    .i_opc (dec_opc),
    .o_cls (dec_cls),
    .o_bad (dec_bad)
  );

  idec_operand_mask #(
    .XLEN(XLEN), .REG_W(REG_W)
  ) u_mask (
    .i_cls  (dec_cls),
    .i_fa   (fld_a),
    .i_fb   (fld_b),
    .i_fc   (fld_c),
    .i_sext (fld_sext),
    .o_ra   (msk_a),
    .o_rb   (msk_b),
    .o_rc   (msk_c),
    .o_imm  (msk_imm)
  );

  // Output register stage: loads only when the strobe is high.
  always_ff @(posedge clk) begin
    if (rst) begin
      o_valid   <= 1'b0;
      o_class   <= CLS_ALU;
      o_opcode  <= '0;
      o_ra      <= '0;
      o_rb      <= '0;
      o_rc      <= '0;
      o_imm     <= '0;
      o_illegal <= 1'b0;
    end else begin
      o_valid <= i_valid;
      if (i_valid) begin
        o_class   <= dec_cls;
        o_opcode  <= dec_opc;
        o_ra      <= msk_a;
        o_rb      <= msk_b;
        o_rc      <= msk_c;
        o_imm     <= msk_imm;
        o_illegal <= dec_bad;
      end
    end
  end

  // R2: the strobe appears one edge later.
  a_r2_valid_follows: assert property (@(posedge clk) disable iff (rst)
    i_valid |=> o_valid);

  // R3: fields hold across an idle cycle.
  a_r3_hold_idle: assert property (@(posedge clk) disable iff (rst)
    (!i_valid && !$past(rst)) |=> ($stable(o_opcode) && $stable(o_imm) && $stable(o_ra)));

  // R7: immediate upper bits are copies of its sign bit.
  a_r7_sign_copy: assert property (@(posedge clk) disable iff (rst)
    (o_class == CLS_IMM) |-> (o_imm[XLEN-1:IMM_W] == {EXT_W{o_imm[IMM_W-1]}}));

  // R8: jump format carries only register a.
  a_r8_jump_zeros: assert property (@(posedge clk) disable iff (rst)
    (o_class == CLS_JMP) |-> (o_rb == '0 && o_rc == '0 && o_imm == '0));

  // R9: operand-free format carries no operands.
  a_r9_misc_zeros: assert property (@(posedge clk) disable iff (rst)
    (o_class == CLS_MISC) |-> (o_ra == '0 && o_rb == '0 && o_rc == '0 && o_imm == '0));

  // R10: an illegal code always lands in the operand-free format.
  a_r10_illegal_misc: assert property (@(posedge clk) disable iff (rst)
    o_illegal |-> (o_class == CLS_MISC));
endmodule

// File: tb/insn_field_decoder_bench.sv
module insn_field_decoder_bench;
  logic        clk = 1'b0;
  logic        rst;
  logic        i_valid;
  logic [31:0] i_instr;
  logic        o_valid;
  logic [1:0]  o_class;
  logic [5:0]  o_opcode;
  logic [4:0]  o_ra, o_rb, o_rc;
  logic [31:0] o_imm;
  logic        o_illegal;

  int n_cmp = 0;
  int n_bad = 0;
  int cycles = 0;

  // Reference model state: what the outputs should show next.
  logic        e_valid, e_ill;
  logic [1:0]  e_cls;
  logic [5:0]  e_opc;
  logic [4:0]  e_ra, e_rb, e_rc;
  logic [31:0] e_imm;

  always #5 clk = ~clk;

  insn_field_decoder u_insn_field_decoder (
    .clk(clk), .rst(rst), .i_valid(i_valid), .i_instr(i_instr),
    .o_valid(o_valid), .o_class(o_class), .o_opcode(o_opcode),
    .o_ra(o_ra), .o_rb(o_rb), .o_rc(o_rc), .o_imm(o_imm),
    .o_illegal(o_illegal)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
  end

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Tag for the requirement that governs the current expected class.
  function automatic string cls_tag(input logic [1:0] c, input logic [5:0] op);
    if (op > 6'd27) return "R10";
    case (c)
      2'd0: return "R5";
      2'd1: return "R6";
      2'd2: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic compare_all(input bit in_reset);
    string t;
    t = in_reset ? "R1" : cls_tag(e_cls, e_opc);
    chk(in_reset ? "R1" : "R2", "valid", {31'd0, o_valid}, {31'd0, e_valid});
    chk(in_reset ? "R1" : "R4", "opcode", {26'd0, o_opcode}, {26'd0, e_opc});
    chk(t, "class", {30'd0, o_class}, {30'd0, e_cls});
    chk(t, "ra", {27'd0, o_ra}, {27'd0, e_ra});
    chk(t, "rb", {27'd0, o_rb}, {27'd0, e_rb});
    chk(t, "rc", {27'd0, o_rc}, {27'd0, e_rc});
    chk((!in_reset && e_cls == 2'd1) ? "R7" : t, "imm", o_imm, e_imm);
    chk(in_reset ? "R1" : "R10", "illegal", {31'd0, o_illegal}, {31'd0, e_ill});
  endtask

  // Behavioural model of one edge (R3 hold when strobe low).
  task automatic model_edge(input bit r, input bit v, input logic [31:0] w);
    int op;
    int imm;
    if (r) begin
      e_valid = 0; e_cls = 0; e_opc = 0; e_ra = 0; e_rb = 0; e_rc = 0; e_imm = 0; e_ill = 0;
      return;
    end
    e_valid = v;
    if (!v) return;
    op = int'(w[31:26]);
    imm = int'(w[15:0]);
    if (imm >= 32768) imm = imm - 65536;
    e_opc = w[31:26];
    e_ill = (op > 27);
    e_ra = 0; e_rb = 0; e_rc = 0; e_imm = 0;
    if (op < 11) begin
      e_cls = 0; e_ra = w[25:21]; e_rb = w[20:16]; e_rc = w[15:11];
    end else if (op < 25) begin
      e_cls = 1; e_ra = w[25:21]; e_rb = w[20:16]; e_imm = 32'(imm);
    end else if (op < 27) begin
      e_cls = 2; e_ra = w[25:21];
    end else begin
      e_cls = 3;
    end
  endtask

  // One cycle: compare at the falling edge, then drive the next inputs.
  task automatic step(input bit r, input bit v, input logic [31:0] w);
    @(negedge clk);
    compare_all(rst);
    rst = r; i_valid = v; i_instr = w;
    model_edge(r, v, w);
  endtask

  initial begin
    rst = 1'b1; i_valid = 1'b1; i_instr = 32'hFFFF_FFFF;
    model_edge(1, 0, 0);
    @(negedge clk);
    step(1, 1, 32'h1234_5678);
    step(1, 1, 32'hDEAD_BEEF);
    step(0, 0, 32'h0);
    // Sweep every code, alternating immediate sign (R4..R10).
    for (int op = 0; op < 64; op++) begin
      logic [31:0] w;
      w = {6'(op), 5'(op + 3), 5'(31 - op), (op % 2 == 1) ? 16'h8001 : 16'h7FFE};
      step(0, 1, w);
    end
    // Class edges with idle gaps (R3).
    step(0, 1, {6'd24, 5'd7, 5'd9, 16'h8000});
    step(0, 0, {6'd2, 5'd1, 5'd1, 16'hFFFF});
    step(0, 0, {6'd40, 5'd1, 5'd1, 16'hFFFF});
    step(0, 1, {6'd24, 5'd7, 5'd9, 16'h7FFF});
    step(0, 1, {6'd11, 5'd31, 5'd31, 16'hFFFF});
    step(0, 1, {6'd10, 5'd31, 5'd30, 16'hFFFF});
    step(0, 1, {6'd25, 5'd17, 5'd18, 16'hABCD});
    step(0, 1, {6'd26, 5'd19, 5'd20, 16'h1234});
    step(0, 1, {6'd27, 5'd21, 5'd22, 16'h9999});
    step(0, 1, {6'd28, 5'd21, 5'd22, 16'h9999});
    step(0, 0, 32'h0);
    // Random words with random strobe.
    for (int i = 0; i < 300; i++) begin
      step(0, 1'($urandom_range(0, 3) != 0), $urandom);
    end
    // Reset in the middle of traffic (R1).
    step(1, 1, 32'hFFFF_FFFF);
    step(0, 0, 32'h0);
    step(0, 1, {6'd5, 5'd1, 5'd2, 5'd3, 11'h0});
    step(0, 0, 32'h0);
    @(negedge clk);
    compare_all(rst);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  // Watchdog.
  initial begin
    wait (cycles >= 5000);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=<5000", cycles);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule